// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that runs in the 32768 Hz slow-clock domain. A prescaler divides the slow clock by `PRESC_DIV`; the default of 128 gives 256 count ticks per second. A 12-bit down-counter is loaded with a programmed reload value. A timeout of N seconds uses the reload value N×256−1, for N from 1 to 16. When the counter passes below zero, the block records an underflow and raises the interrupt output, the reset request, or both, depending on the enables that software has set.

Software keeps the system alive by writing a keyed restart command. A restart is welcome only once the counter has fallen to or below a programmed window value. A restart that arrives earlier counts as a window error and is treated exactly like an underflow. After every accepted restart, the block drops register writes for three slow-clock periods. While the block is disabled, its two timing fields cannot be changed. Idle and debug halt inputs can freeze counting when the matching mode bits allow it.

Top module: `slowclk_window_wdt`

## Requirements
- R1: After reset the mode register (rd_sel=1) reads 0x1FFF0FFF: disabled, reload 0xFFF, window 0xFFF, all enables clear. The status register reads 0, and irq_o and rst_req_o are low.
- R2: The mode register is selected by wr_sel=1. Its bit fields are: [11:0] reload, [12] interrupt enable, [13] reset enable, [14] idle-halt enable, [15] debug-halt enable, [27:16] window, [28] disable. An accepted mode write while enabled reloads the counter. The underflow flag (status bit 0) then sets exactly (reload+1)×PRESC_DIV cycles after the write edge, and not one cycle earlier.
- R3: A restart is a write with wr_sel=0, 0xA5 in bits [31:24] and bit 0 set. It reloads the counter from the reload field. A write with any other key changes nothing.
- R4: A restart accepted while enabled with the counter above the window field sets the window-error flag (status bit 1) and raises the same fault outputs as an underflow. A restart at or below the window value raises nothing.
- R5: For the three cycles after an accepted restart, control and mode writes are dropped. A write in the fourth cycle is accepted.
- R6: A mode write accepted while the disable bit is stored, or while it carries a set disable bit, leaves the reload and window fields unchanged and updates the other fields.
- R7: A fault with the interrupt enable set drives irq_o high. A fault with the reset enable set gives a one-cycle rst_req_o pulse on the edge where the fault occurs.
- R8: Reading status (rd_sel=2, rd_en) returns the flags and clears them on that edge, so irq_o drops.
- R9: The counter holds while idle_halt_i is high and the idle-halt enable is set, and likewise for debug_halt_i with the debug-halt enable. With the enable clear, the halt input has no effect.
- R10: While disabled, the block does not count and raises no fault.
- R11: An underflow reloads the counter, so faults repeat every (reload+1)×PRESC_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 mode |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read target: 1 mode, 2 status, others read 0 |
| rd_data | output | 32 | Read data for rd_sel, combinational |
| idle_halt_i | input | 1 | System idle indication |
| debug_halt_i | input | 1 | Debugger halt indication |
| irq_o | output | 1 | Fault interrupt, level |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Faults in the counter or the prescaler show only as a shift in the edge where the status flag sets. The tests therefore read status one cycle before and exactly on the expected underflow edge, which exposes any off-by-one at once. A wrong lockout count or a wrong key compare shows within a few cycles as a changed mode readback. A missed reload shows later, as an underflow that arrives a full period early. Window errors and halt gating show as a flag and a reset pulse that appear at the wrong edge, or do not appear at all.

// File: rtl/slowclk_window_wdt.sv
module slowclk_window_wdt #(
  parameter int          PRESC_DIV = 128,
  parameter int          CNT_W     = 12,
  parameter int          LOCK_CYC  = 3,
  parameter logic [7:0]  KEY       = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        idle_halt_i,
  input  logic        debug_halt_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_MODE = 2'd1, SEL_STAT = 2'd2;
  localparam int DLT_LSB = 16;

  logic [CNT_W-1:0] cv_q, dlt_q, cnt_q;
  logic             fien_q, rsten_q, hidle_q, hdbg_q, dis_q;
  logic [PW-1:0]    pre_q;
  logic [LW-1:0]    lock_q;
  logic             uf_q, err_q, rst_req_q;
  logic [31:0]      mode_word;

  wire unlocked = (lock_q == '0);
  wire mode_wr  = wr_en && wr_sel == SEL_MODE && unlocked;
  wire restart  = wr_en && wr_sel == SEL_CTRL && unlocked && wr_data[31:24] == KEY && wr_data[0];
  wire freeze   = dis_q || wr_data[28];
  wire halted   = (idle_halt_i && hidle_q) || (debug_halt_i && hdbg_q);
  wire run      = !dis_q && !halted;
  wire tick     = run && pre_q == PW'(PRESC_DIV - 1);
  wire under    = tick && cnt_q == '0 && !mode_wr && !restart;
  wire win_err  = restart && !dis_q && cnt_q > dlt_q;
  wire fault    = under || win_err;
  wire st_rd    = rd_en && rd_sel == SEL_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= '1; dlt_q <= '1; dis_q <= 1'b1;
      fien_q <= 1'b0; rsten_q <= 1'b0; hidle_q <= 1'b0; hdbg_q <= 1'b0;
    end else if (mode_wr) begin
      fien_q  <= wr_data[12];
      rsten_q <= wr_data[13];
      hidle_q <= wr_data[14];
      hdbg_q  <= wr_data[15];
      dis_q   <= wr_data[28];
      if (!freeze) begin
        cv_q  <= wr_data[CNT_W-1:0];
        dlt_q <= wr_data[DLT_LSB +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      pre_q <= '0;
    end else if (mode_wr) begin
      cnt_q <= freeze ? cv_q : wr_data[CNT_W-1:0];
      pre_q <= '0;
    end else if (restart) begin
      cnt_q <= cv_q;
      pre_q <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= (cnt_q == '0) ? cv_q : cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= '0;
      uf_q      <= 1'b0;
      err_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (restart)        lock_q <= LW'(LOCK_CYC);
      else if (!unlocked) lock_q <= lock_q - 1'b1;
      uf_q      <= (uf_q && !st_rd) || under;
      err_q     <= (err_q && !st_rd) || win_err;
      rst_req_q <= fault && rsten_q;
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[CNT_W-1:0]         = cv_q;
    mode_word[12]                = fien_q;
    mode_word[13]                = rsten_q;
    mode_word[14]                = hidle_q;
    mode_word[15]                = hdbg_q;
    mode_word[DLT_LSB +: CNT_W]  = dlt_q;
    mode_word[28]                = dis_q;
  end

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_data = mode_word;
      SEL_STAT: rd_data = {30'd0, err_q, uf_q};
      default:  rd_data = '0;
    endcase
  end

  assign irq_o     = fien_q && (uf_q || err_q);
  assign rst_req_o = rst_req_q;

  assert_lock_drops_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != '0) |=> $stable(mode_word));

  assert_frozen_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> $stable({cv_q, dlt_q}));

  assert_no_count_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> ($stable(cnt_q) || cnt_q == cv_q));

  assert_rst_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(rsten_q));

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !mode_wr && !restart) |=> $stable(cnt_q));
endmodule

// File: tb/slowclk_window_wdt_tb_top.sv
`timescale 1ns/1ps
module slowclk_window_wdt_tb_top;
  localparam int D = 8;
  localparam logic [31:0] M_BASE = 32'h0003_3003;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic idle_halt_i = 1'b0, debug_halt_i = 1'b0;
  logic irq_o, rst_req_o;

  int n_run = 0, n_fail = 0, n_rst = 0;
  bit done = 0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  slowclk_window_wdt #(.PRESC_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .idle_halt_i(idle_halt_i), .debug_halt_i(debug_halt_i),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  always @(posedge clk) begin
    #1;
    if (rst_n && rst_req_o) n_rst++;
  end

  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (rd_data !== e.v) begin
        n_fail++;
        $display("FAIL %s: got %08h expected %08h", e.tag, rd_data, e.v);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag;
    sb.push_back(e);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, 32'h1FFF_0FFF, "R1 mode reset");
    rd(2'd2, 32'h0, "R1 status reset");
    chk("R1 irq reset", irq_o, 0);
    chk("R1 rst_req reset", rst_req_o, 0);
    wr(2'd1, 32'h1003_3003);
    rd(2'd1, 32'h1FFF_3FFF, "R6 frozen while disabled");
    wr(2'd1, M_BASE);
    rd(2'd1, 32'h0FFF_3FFF, "R6 frozen on enabling write");
    wr(2'd1, M_BASE);
    rd(2'd1, M_BASE, "R2 mode accepted");
    skip(30);
    rd(2'd2, 32'h0, "R2 no underflow one cycle early");
    chk("R7 reset pulse count", n_rst, 1);
    chk("R7 irq on underflow", irq_o, 1);
    rd(2'd2, 32'h1, "R2 underflow on time");
    chk("R8 irq drops after read", irq_o, 0);
    rd(2'd2, 32'h0, "R8 status cleared");
    skip(30);
    chk("R11 periodic reset count", n_rst, 2);
    rd(2'd2, 32'h1, "R11 second underflow");
    chk("R7 reset pulse one cycle", rst_req_o, 0);
    wr(2'd1, M_BASE);
    skip(9);
    wr(2'd0, 32'h5A00_0001);
    skip(21);
    rd(2'd2, 32'h0, "R3 wrong key early check");
    rd(2'd2, 32'h1, "R3 wrong key ignored");
    wr(2'd1, M_BASE);
    skip(9);
    wr(2'd0, 32'hA500_0001);
    wr(2'd1, 32'h0000_3003);
    rd(2'd1, M_BASE, "R5 write dropped after restart");
    skip(29);
    rd(2'd2, 32'h0, "R3 restart reloaded");
    rd(2'd2, 32'h1, "R3 underflow after restart");
    chk("R3 reset count", n_rst, 4);
    wr(2'd0, 32'hA500_0001);
    wr(2'd1, 32'h0003_2003);
    rd(2'd1, M_BASE, "R5 write in lock window dropped");
    skip(1);
    wr(2'd1, 32'h0002_3003);
    rd(2'd1, 32'h0002_3003, "R5 fourth cycle accepted");
    wr(2'd0, 32'hA500_0001);
    chk("R4 window error reset", n_rst, 5);
    chk("R4 window error irq", irq_o, 1);
    rd(2'd2, 32'h2, "R4 window error flag");
    skip(8);
    wr(2'd0, 32'hA500_0001);
    rd(2'd2, 32'h0, "R4 restart inside window");
    chk("R4 no reset inside window", n_rst, 5);
    skip(3);
    wr(2'd1, 32'h0003_7003);
    idle_halt_i = 1'b1;
    skip(20);
    idle_halt_i = 1'b0;
    skip(31);
    rd(2'd2, 32'h0, "R9 idle halt delayed underflow");
    rd(2'd2, 32'h1, "R9 underflow after halt");
    debug_halt_i = 1'b1;
    skip(30);
    rd(2'd2, 32'h0, "R9 debug input without enable early");
    rd(2'd2, 32'h1, "R9 debug input without enable ignored");
    wr(2'd1, 32'h1003_7003);
    rd(2'd1, 32'h1003_7003, "R10 disabled mode");
    wr(2'd1, 32'h1005_7005);
    rd(2'd1, 32'h1003_7003, "R6 timing frozen while disabled");
    skip(100);
    rd(2'd2, 32'h0, "R10 no fault when disabled");
    chk("R10 no reset when disabled", n_rst, 7);
    skip(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule